// File: doc/BRIEF.md
# Trimmed One-Second Prescaler with BCD Seconds

This block turns an oscillator-rate clock enable into a one-second tick and keeps a BCD seconds count from 00 to 59. Every twenty seconds it applies a small signed digital correction to the divide ratio, so that crystal frequency error can be cancelled in steps of two oscillator cycles. The raw oscillator enable is also passed straight through to an output, and the trim setting has no effect on it.

Software programs one 8-bit trim register. The top bit selects the nominal ratio between two crystal rates. The next bit and the low six bits select a lengthening or a shortening of the corrected second, with a dead band where no correction is applied. A write never changes a second that is already being counted. The new value takes effect from the next second boundary. An oscillator-stop indication clears the trim register. A one-cycle carry pulse on the 59-to-00 wrap feeds a minutes stage.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset, sec_bcd is 8'h00, trim_rdata is 8'h00, and sec_tick and min_carry are both 0.
- R2: trim_rdata returns the last value written with trim_we. osc_stop clears the register to 8'h00, and it takes priority over a write in the same cycle.
- R3: A second with no correction lasts NOM_A oscillator enables when trim bit 7 is 0, and NOM_B enables when bit 7 is 1.
- R4: Seconds whose BCD value is anything other than 8'h00, 8'h20 or 8'h40 always use the nominal ratio from R3, whatever bits 6..0 hold.
- R5: During seconds 00, 20 and 40, with bit 6 = 0 and bits 5..1 not all zero, the second lasts the nominal ratio plus (bits5..0 − 1)×2 enables. For example, 8'h07 gives NOM_A+12.
- R6: During seconds 00, 20 and 40, with bit 6 = 1 and bits 5..1 not all zero, the second lasts the nominal ratio minus ((63 − bits5..0) + 1)×2 enables. For example, 8'h7E gives NOM_A−4.
- R7: When bits 5..1 are all zero, no correction is applied, whatever bits 6 and 0 hold. For example, 8'h01 and 8'h41 give the nominal ratio.
- R8: The length of each second is fixed by the register value held before the boundary clock edge that starts it. A write in the same cycle as a boundary applies only from the following boundary.
- R9: sec_bcd counts 00..59 in BCD and wraps to 00. sec_tick is a one-cycle pulse, and sec_bcd shows the new value in the same cycle as that pulse.
- R10: min_carry pulses for one cycle together with the sec_tick that wraps sec_bcd from 59 to 00, and is 0 at all other times.
- R11: osc_out equals osc_tick in the same cycle, independent of the trim value.
- R12: Cycles with osc_tick low do not advance the second count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_stop | input | 1 | Oscillator-stop indication; clears the trim register |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| trim_we | input | 1 | Trim register write strobe |
| trim_wdata | input | 8 | Trim register write data |
| trim_rdata | output | 8 | Trim register read data |
| osc_out | output | 1 | Uncorrected oscillator enable pass-through |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |
| sec_bcd | output | 8 | Current seconds value, BCD |
| min_carry | output | 1 | Pulse on the 59-to-00 wrap |

## Verification
A register write and a second boundary can fall on the same clock edge. The divider then latches the coming second's length at the moment the register changes. The bench deliberately drives a write together with the oscillator enable that completes a second. It also drives writes together with osc_stop. A reference model then predicts the length of each following second from the register value held before that edge. Any second that is counted with the new value too early, or that is cut short, shows up as a mismatch in the measured number of enables between ticks.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   localparam int TRIM_W = 8;
   localparam int CORR_W = 9;

   typedef logic [TRIM_W-1:0] trim_t;
   typedef logic [7:0]        bcd_sec_t;

   // signed correction in oscillator cycles, dead band when bits 5..1 are zero
   function automatic logic signed [CORR_W-1:0] trim_correction(input trim_t t);
      int f;
      int v;
      f = int'(t[5:0]);
      if (t[5:1] == 5'd0)
         v = 0;
      else if (!t[6])
         v = (f - 1) * 2;
      else
         v = -(((63 - f) + 1) * 2);
      return CORR_W'(v);
   endfunction

   function automatic logic is_trim_second(input bcd_sec_t s);
      return (s == 8'h00) || (s == 8'h20) || (s == 8'h40);
   endfunction

   function automatic bcd_sec_t bcd_sec_next(input bcd_sec_t s, input bcd_sec_t last);
      if (s == last)
         return 8'h00;
      else if (s[3:0] == 4'd9)
         return {s[7:4] + 4'd1, 4'h0};
      else
         return {s[7:4], s[3:0] + 4'd1};
   endfunction

endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
   import rtc_trim_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  osc_stop,
   input  logic  we,
   input  trim_t wdata,
   output trim_t q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (osc_stop)
         q <= '0;
      else if (we)
         q <= wdata;
   end

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop |=> (q == '0)); // R2
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !osc_stop) |=> (q == $past(wdata))); // R2

endmodule

// File: rtl/rtc_bcd_seconds.sv
module rtc_bcd_seconds
   import rtc_trim_pkg::*;
#(
   parameter bcd_sec_t LAST_SEC = 8'h59
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   output bcd_sec_t sec_q,
   output logic     tick_q,
   output logic     carry_q
);

   if (LAST_SEC[3:0] > 4'd9 || LAST_SEC[7:4] > 4'd9) begin : g_bad_last
      $error("LAST_SEC must be a BCD value");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q   <= 8'h00;
         tick_q  <= 1'b0;
         carry_q <= 1'b0;
      end else begin
         tick_q  <= adv;
         carry_q <= adv && (sec_q == LAST_SEC);
         if (adv)
            sec_q <= bcd_sec_next(sec_q, LAST_SEC);
      end
   end

   AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q[3:0] <= 4'd9) && (sec_q <= LAST_SEC)); // R9
   AST_SEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(sec_q)); // R12

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
   import rtc_trim_pkg::*;
#(
   parameter int       NOM_A    = 32768,
   parameter int       NOM_B    = 32000,
   parameter bit       TRIM_EN  = 1'b1,
   parameter bcd_sec_t LAST_SEC = 8'h59,
   parameter int       PER_W    = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     osc_tick,
   input  trim_t    trim,
   input  bcd_sec_t sec_now,
   output logic     bound
);

   logic [PER_W-1:0]         cnt_q;
   logic [PER_W-1:0]         period_q;
   logic [PER_W-1:0]         period_d;
   logic signed [CORR_W-1:0] corr_eff;
   bcd_sec_t                 sec_after;

   assign sec_after = bcd_sec_next(sec_now, LAST_SEC);

   if (TRIM_EN) begin : g_trim
      assign corr_eff = is_trim_second(sec_after) ? trim_correction(trim) : '0;
   end else begin : g_plain
      assign corr_eff = '0;
   end

   always_comb begin
      int p;
      p = (trim[7] ? NOM_B : NOM_A) + int'(corr_eff);
      period_d = PER_W'(p);
   end

   assign bound = osc_tick && (cnt_q == period_q - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         period_q <= PER_W'(NOM_A);
      end else if (bound) begin
         cnt_q    <= '0;
         period_q <= period_d;
      end else if (osc_tick) begin
         cnt_q    <= cnt_q + PER_W'(1);
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < period_q); // R3
   AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bound |=> $stable(period_q)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int       NOM_A    = 32768,
   parameter int       NOM_B    = 32000,
   parameter bit       TRIM_EN  = 1'b1,
   parameter bcd_sec_t LAST_SEC = 8'h59
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_stop,
   input  logic       osc_tick,
   input  logic       trim_we,
   input  logic [7:0] trim_wdata,
   output logic [7:0] trim_rdata,
   output logic       osc_out,
   output logic       sec_tick,
   output logic [7:0] sec_bcd,
   output logic       min_carry
);

   localparam int MAX_EXT   = 62 * 2;
   localparam int MAX_SHORT = 62 * 2;
   localparam int MAX_NOM   = (NOM_A > NOM_B) ? NOM_A : NOM_B;
   localparam int MIN_NOM   = (NOM_A < NOM_B) ? NOM_A : NOM_B;
   localparam int PER_W     = $clog2(MAX_NOM + MAX_EXT + 1);

   if (MIN_NOM < MAX_SHORT + 2) begin : g_bad_nom
      $error("nominal ratios too small for the largest shortening");
   end

   trim_t trim_q;
   logic  bound;

   assign osc_out    = osc_tick;
   assign trim_rdata = trim_q;

   rtc_trim_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .osc_stop (osc_stop),
      .we    (trim_we),
      .wdata (trim_wdata),
      .q     (trim_q)
   );

   rtc_trim_divider #(
      .NOM_A    (NOM_A),
      .NOM_B    (NOM_B),
      .TRIM_EN  (TRIM_EN),
      .LAST_SEC (LAST_SEC),
      .PER_W    (PER_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .trim     (trim_q),
      .sec_now  (sec_bcd),
      .bound    (bound)
   );

   rtc_bcd_seconds #(
      .LAST_SEC (LAST_SEC)
   ) u_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (bound),
      .sec_q   (sec_bcd),
      .tick_q  (sec_tick),
      .carry_q (min_carry)
   );

   AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick); // R9
   AST_CARRY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      min_carry |-> (sec_tick && sec_bcd == 8'h00)); // R10

endmodule

// File: tb/rtc_trim_prescaler_tb_top.sv
module rtc_trim_prescaler_tb_top;

   localparam int NA = 200;
   localparam int NB = 160;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       osc_stop, osc_tick, trim_we;
   logic [7:0] trim_wdata, trim_rdata, sec_bcd;
   logic       osc_out, sec_tick, min_carry;

   always #10 clk = ~clk;

   rtc_trim_prescaler #(.NOM_A(NA), .NOM_B(NB)) dut_i (
      .clk (clk), .rst_n (rst_n), .osc_stop (osc_stop), .osc_tick (osc_tick),
      .trim_we (trim_we), .trim_wdata (trim_wdata), .trim_rdata (trim_rdata),
      .osc_out (osc_out), .sec_tick (sec_tick), .sec_bcd (sec_bcd),
      .min_carry (min_carry)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] reg_m, reg_b, sec_m;
   int  tick_cnt, exp_cur, coincide, wraps;
   string tag_cur;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_period(input logic [7:0] t, input logic [7:0] s);
      int b = t[7] ? NB : NA;
      int f = int'(t[5:0]);
      if (!(s == 8'h00 || s == 8'h20 || s == 8'h40)) return b;
      if (f / 2 == 0) return b;
      if (!t[6]) return b + (f - 1) * 2;
      return b - ((63 - f) + 1) * 2;
   endfunction

   function automatic string exp_tag(input logic [7:0] t, input logic [7:0] s, input bit late);
      if (late) return "R8";
      if (!(s == 8'h00 || s == 8'h20 || s == 8'h40))
         return (t[5:1] != 5'd0) ? "R4" : "R3";
      if (t[5:1] == 5'd0) return "R7";
      return t[6] ? "R6" : "R5";
   endfunction

   function automatic logic [7:0] sec_next(input logic [7:0] s);
      int v = (s[7:4] * 10 + s[3:0] + 1) % 60;
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic step(input bit o, input bit we, input bit stop, input logic [7:0] wd);
      logic [7:0] prev;
      osc_tick = o; trim_we = we; osc_stop = stop; trim_wdata = wd;
      #1;
      check(osc_out == o, "R11 osc_out", int'(osc_out), int'(o));
      @(posedge clk);
      @(negedge clk);
      reg_b = reg_m;
      if (stop) reg_m = 8'h00;
      else if (we) reg_m = wd;
      if (o) tick_cnt++;
      check(trim_rdata == reg_m, "R2 trim_rdata", int'(trim_rdata), int'(reg_m));
      if (sec_tick) begin
         check(tick_cnt == exp_cur, {tag_cur, " second length"}, tick_cnt, exp_cur);
         tick_cnt = 0;
         prev  = sec_m;
         sec_m = sec_next(sec_m);
         if (prev == 8'h59) wraps++;
         check(min_carry == (prev == 8'h59), "R10 min_carry at tick", int'(min_carry),
               int'(prev == 8'h59));
         exp_cur = exp_period(reg_b, sec_m);
         tag_cur = exp_tag(reg_b, sec_m, reg_b != reg_m);
      end else begin
         check(!min_carry, "R10 min_carry idle", int'(min_carry), 0);
      end
      check(sec_bcd == sec_m, "R9 sec_bcd", int'(sec_bcd), int'(sec_m));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] wd;
      bit o, we, stop;
      void'($urandom(32'd1234));
      rst_n = 1'b0; osc_tick = 0; osc_stop = 0; trim_we = 0; trim_wdata = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(sec_bcd == 8'h00, "R1 sec_bcd", int'(sec_bcd), 0);
      check(trim_rdata == 8'h00, "R1 trim_rdata", int'(trim_rdata), 0);
      check(!sec_tick && !min_carry, "R1 pulses", int'(sec_tick) + int'(min_carry), 0);
      reg_m = 8'h00; sec_m = 8'h00; tick_cnt = 0; coincide = 0; wraps = 0;
      exp_cur = NA; tag_cur = "R3";
      while (wraps < 2) begin
         o    = ($urandom % 4) != 0;            // R12: gaps in the enable
         we   = ($urandom % 300) == 0;
         stop = ($urandom % 2500) == 0;
         if (stop) we = ($urandom % 2) == 0;      // R2: stop against write
         if (o && tick_cnt + 1 == exp_cur && ($urandom % 3) == 0) begin
            we = 1'b1;                            // R8: write on the boundary
            coincide++;
         end
         case ($urandom % 8)
            0: wd = 8'h07;
            1: wd = 8'h7E;
            2: wd = 8'h01;
            3: wd = 8'h41;
            4: wd = 8'h80;
            5: wd = 8'hC2;
            6: wd = 8'h3F;
            default: wd = 8'($urandom);
         endcase
         step(o, we, stop, wd);
      end
      check(coincide > 0, "R8 boundary writes seen", coincide, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule